// File: doc/BRIEF.md
# Four-Strobe Control-Bus Register Target

This block is the target side of a narrow control bus in which a master moves each transfer through separate strobes over a shared 16-bit input bus. One strobe stores the bus value as the register address. A second stores it as pending write data. A third commits that pending data to the stored address. A fourth returns the word at the stored address on a 16-bit output bus. Each strobe is a four-phase handshake: the target performs the action, raises ack after a programmable delay, keeps ack high while the strobe stays high, and lowers it once the strobe has dropped.

Behind the port sits a small register array of `NUM_WORDS` 16-bit words. The array gives a master sequencer a partner whose contents it can read back after a read-modify-write sequence. Only addresses below `NUM_WORDS` reach storage. A master that raises two strobes at once gets no ack and sees an error flag instead.

Top module: `cr_target_port`

## Requirements
- R1: A rising edge on `cap_addr_i` stores `din_i` as the current address; the stored address changes on no other event but reset.
- R2: A rising edge on `cap_data_i` stores `din_i` as the pending write data; the pending data changes on no other event but reset.
- R3: A rising edge on `wr_i` writes the pending data to the word at the stored address; the value on `din_i` during the write strobe is ignored, and data captured without a later write never reaches storage.
- R4: A rising edge on `rd_i` loads `dout_o` with the word at the stored address; `dout_o` holds that value for as long as `ack_o` is high.
- R5: `ack_o` rises exactly `ACK_LAT` clock cycles after the cycle in which a single strobe is first sampled high. It stays high while that strobe is held and falls one cycle after the strobe is sampled low. A strobe that stays high triggers only one action.
- R6: An address is in range when it is below `NUM_WORDS`. A read from an address out of range returns 0, and a write to one is dropped without touching any word, including the word its low bits would alias to.
- R7: When more than one of the four strobes is sampled high, no action is taken and `ack_o` is low from the next cycle on. `proto_err_o` is high from the next cycle until one cycle after all strobes are sampled low.
- R8: Reset (`rst_n` low, asynchronous) clears every stored word, the stored address, the pending data, `dout_o`, `ack_o` and `proto_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din_i | input | 16 | Address or data bus from the master |
| cap_addr_i | input | 1 | Strobe: store `din_i` as the address |
| cap_data_i | input | 1 | Strobe: store `din_i` as pending write data |
| wr_i | input | 1 | Strobe: commit pending data to the stored address |
| rd_i | input | 1 | Strobe: return the word at the stored address |
| ack_o | output | 1 | Handshake acknowledge |
| dout_o | output | 16 | Read data, valid while `ack_o` is high |
| proto_err_o | output | 1 | More than one strobe was high at once |

## Verification
All inputs change on the falling clock edge, and every result is sampled on a later falling edge. A strobe is first seen at the next rising edge. At that edge the action completes, so ack is due `ACK_LAT` rising edges later: the bench counts falling edges until ack and expects `ACK_LAT`+1. Read data is sampled in the cycle ack is first seen. After the strobe is dropped, ack is checked on the very next falling edge. The error flag is checked on the falling edge after a second strobe appears, and its release on the falling edge after all strobes are dropped.

// File: rtl/cr_target_port.sv
module cr_target_port #(
  parameter int DATA_W    = 16,
  parameter int NUM_WORDS = 16,
  parameter int ACK_LAT   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din_i,
  input  logic              cap_addr_i,
  input  logic              cap_data_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] dout_o,
  output logic              proto_err_o
);

  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam int CNT_W = (ACK_LAT > 1) ? $clog2(ACK_LAT) : 1;
  localparam logic [DATA_W:0]  LIMIT    = (DATA_W+1)'(NUM_WORDS);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ACK_LAT - 1);

  typedef enum logic [1:0] {IDLE, WAIT, HOLD, ERR} state_t;

  state_t            st_q;
  logic [3:0]        stb, stb_q, act_q, rise;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] addr_q, data_q;
  logic [DATA_W-1:0] mem [NUM_WORDS];
  logic              multi, start, in_rng, act_on;
  logic [IDX_W-1:0]  idx;

  assign stb    = {rd_i, wr_i, cap_data_i, cap_addr_i};
  assign rise   = stb & ~stb_q;
  assign multi  = (stb & (stb - 4'd1)) != 4'd0;
  assign start  = (st_q == IDLE) && !multi && (rise != 4'd0);
  assign act_on = (stb & act_q) != 4'd0;
  assign in_rng = {1'b0, addr_q} < LIMIT;
  assign idx    = addr_q[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= IDLE;
      stb_q       <= '0;
      act_q       <= '0;
      cnt_q       <= '0;
      addr_q      <= '0;
      data_q      <= '0;
      dout_o      <= '0;
      ack_o       <= 1'b0;
      proto_err_o <= 1'b0;
      for (int i = 0; i < NUM_WORDS; i++) mem[i] <= '0;
    end else begin
      stb_q <= stb;
      case (st_q)
        IDLE: begin
          if (multi) begin
            proto_err_o <= 1'b1;
            st_q        <= ERR;
          end else if (start) begin
            act_q <= rise;
            cnt_q <= CNT_LOAD;
            st_q  <= WAIT;
            if (cap_addr_i) addr_q <= din_i;
            if (cap_data_i) data_q <= din_i;
            if (wr_i && in_rng) mem[idx] <= data_q;
            if (rd_i) dout_o <= in_rng ? mem[idx] : '0;
          end
        end
        WAIT: begin
          if (multi) begin
            proto_err_o <= 1'b1;
            st_q        <= ERR;
          end else if (!act_on) begin
            st_q <= IDLE;
          end else if (cnt_q == '0) begin
            ack_o <= 1'b1;
            st_q  <= HOLD;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        HOLD: begin
          if (multi) begin
            ack_o       <= 1'b0;
            proto_err_o <= 1'b1;
            st_q        <= ERR;
          end else if (!act_on) begin
            ack_o <= 1'b0;
            st_q  <= IDLE;
          end
        end
        default: begin
          if (stb == 4'd0) begin
            proto_err_o <= 1'b0;
            st_q        <= IDLE;
          end
        end
      endcase
    end
  end

  // R1
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_addr_i |=> $stable(addr_q));

  // R2
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_data_i |=> $stable(data_q));

  // R4
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> $stable(dout_o));

  // R5
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && stb == 4'd0) |=> !ack_o);

  // R7
  err_noack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err_o |-> !ack_o);

endmodule

// File: tb/test_cr_target_port.sv
module test_cr_target_port;
  localparam int LAT = 2;
  localparam int NV  = 25;
  localparam logic [1:0] OP_CA = 2'd0, OP_CD = 2'd1, OP_WR = 2'd2, OP_RD = 2'd3;

  // {op, din, expected read data}
  localparam logic [33:0] VEC [NV] = '{
    {OP_CA, 16'h0003, 16'h0000},
    {OP_CD, 16'hA5A5, 16'h0000},
    {OP_WR, 16'hFFFF, 16'h0000},  // R3: bus value during write ignored
    {OP_CD, 16'h0F0F, 16'h0000},  // R3: captured, never committed
    {OP_CA, 16'h0003, 16'h0000},
    {OP_RD, 16'h7777, 16'hA5A5},
    {OP_CA, 16'h0000, 16'h0000},
    {OP_CD, 16'h1234, 16'h0000},
    {OP_WR, 16'h0000, 16'h0000},
    {OP_CA, 16'h000F, 16'h0000},
    {OP_CD, 16'hBEEF, 16'h0000},
    {OP_WR, 16'h0000, 16'h0000},
    {OP_CA, 16'h0000, 16'h0000},
    {OP_RD, 16'h0000, 16'h1234},
    {OP_CA, 16'h000F, 16'h0000},
    {OP_RD, 16'h0000, 16'hBEEF},
    {OP_CA, 16'h0011, 16'h0000},  // R6: out of range, aliases word 1
    {OP_CD, 16'hDEAD, 16'h0000},
    {OP_WR, 16'h0000, 16'h0000},
    {OP_CA, 16'h0011, 16'h0000},
    {OP_RD, 16'h0000, 16'h0000},
    {OP_CA, 16'h0001, 16'h0000},
    {OP_RD, 16'h0000, 16'h0000},
    {OP_CA, 16'h0010, 16'h0000},
    {OP_RD, 16'h0000, 16'h0000}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] din = '0;
  logic ca = 1'b0, cd = 1'b0, wr = 1'b0, rd = 1'b0;
  logic ack, perr;
  logic [15:0] dout;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cr_target_port #(.DATA_W(16), .NUM_WORDS(16), .ACK_LAT(LAT)) i_cr_target_port (
    .clk(clk), .rst_n(rst_n), .din_i(din), .cap_addr_i(ca), .cap_data_i(cd),
    .wr_i(wr), .rd_i(rd), .ack_o(ack), .dout_o(dout), .proto_err_o(perr));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_stb(input logic [1:0] op, input logic v);
    case (op)
      OP_CA: ca = v;
      OP_CD: cd = v;
      OP_WR: wr = v;
      default: rd = v;
    endcase
  endtask

  task automatic strobe(input logic [1:0] op, input logic [15:0] d, input int hold,
                        output logic [15:0] rdat);
    int n = 0;
    @(negedge clk);
    din = d;
    set_stb(op, 1'b1);
    do begin
      @(negedge clk);
      n++;
    end while (!ack && n < 40);
    check(ack && n == LAT + 1, "R5 ack latency", n, LAT + 1);
    rdat = dout;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check(ack == 1'b1, "R5 ack held", ack, 1);
    end
    set_stb(op, 1'b0);
    @(negedge clk);
    check(ack == 1'b0, "R5 ack release", ack, 0);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(20ns * 20000);
    check(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    // R8: reset state
    check(ack == 1'b0, "R8 ack after reset", ack, 0);
    check(perr == 1'b0, "R8 err after reset", perr, 0);
    check(dout == 16'h0, "R8 dout after reset", dout, 0);
    rst_n = 1'b1;
    // R8: address cleared to 0, storage cleared
    strobe(OP_RD, 16'hFFFF, 0, r);
    check(r == 16'h0, "R8 word0 after reset", r, 0);

    for (int v = 0; v < NV; v++) begin
      logic [1:0] op;
      op = VEC[v][33:32];
      strobe(op, VEC[v][31:16], 0, r);
      if (op == OP_RD)
        check(r == VEC[v][15:0], "R1/R2/R3/R4/R6 table read", r, VEC[v][15:0]);
    end

    // R5: held strobe keeps ack, R1 address 3
    strobe(OP_CA, 16'h0003, 5, r);

    // R7: two strobes together
    @(negedge clk);
    din = 16'h0009; ca = 1'b1; rd = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(ack == 1'b0, "R7 no ack on multi", ack, 0);
      check(perr == 1'b1, "R7 err on multi", perr, 1);
    end
    ca = 1'b0; rd = 1'b0;
    @(negedge clk);
    check(perr == 1'b0, "R7 err release", perr, 0);
    strobe(OP_RD, 16'h0000, 0, r);
    check(r == 16'hA5A5, "R7 address not latched", r, 16'hA5A5);

    // R7: second strobe while ack held
    @(negedge clk);
    rd = 1'b1;
    for (int k = 0; k < 10 && !ack; k++) @(negedge clk);
    check(ack == 1'b1, "R7 ack before second strobe", ack, 1);
    wr = 1'b1;
    @(negedge clk);
    check(ack == 1'b0, "R7 ack dropped", ack, 0);
    check(perr == 1'b1, "R7 err raised", perr, 1);
    rd = 1'b0; wr = 1'b0;
    @(negedge clk);
    check(perr == 1'b0, "R7 err cleared", perr, 0);
    strobe(OP_RD, 16'h0000, 0, r);
    check(r == 16'hA5A5, "R7 no write on multi", r, 16'hA5A5);

    // R8: reset mid-run clears storage
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(dout == 16'h0, "R8 dout cleared", dout, 0);
    rst_n = 1'b1;
    strobe(OP_CA, 16'h0003, 0, r);
    strobe(OP_RD, 16'h0000, 0, r);
    check(r == 16'h0, "R8 word cleared", r, 0);

    summary();
  end
endmodule